// File: doc/BRIEF.md
# Stepped Transmit Level Controller

This block is the digital decision loop behind a transmit automatic level control. An external peak detector measures the feedback from the line driver over a window, and two comparators report whether that peak sits under a low threshold or over a high threshold. At the end of each detect window a one-cycle strobe asks the block to act. On that strobe it raises, holds or lowers a 5-bit gain code by one step. A code of 0 is the lowest gain, which is the largest attenuation. A code of 31 is the highest gain. Each step is worth 0.84 dB, so the range is about 26 dB.

The thresholds form a window with a dead band between them. A peak inside the window leaves the code alone. A low peak raises the gain. A high peak lowers it. If both comparator flags are set at once, the block treats this as over-range and lowers the gain. The loop only acts while the transmitter is active, and the code saturates at both ends instead of wrapping.

After a given number of evaluations in a row land inside the window, a settled flag goes high. That number is 2 by default.

Top module: `tx_level_ctrl`

## Requirements
- R1: After reset, gain_code_o is 0 (lowest gain) and settled_o is 0.
- R2: The code and settled state change only on a clock edge where eval_i and tx_active_i are both 1. Strobes while tx_active_i is 0 and cycles without a strobe have no effect. A result appears on the clock edge that samples the strobe.
- R3: On an evaluation with below_lo_i=1 and above_hi_i=0, gain_code_o rises by exactly 1.
- R4: On an evaluation with above_hi_i=1 and below_lo_i=0, gain_code_o falls by exactly 1.
- R5: On an evaluation with both below_lo_i=1 and above_hi_i=1, gain_code_o falls by exactly 1.
- R6: On an evaluation with both flags 0 (inside the window), gain_code_o is unchanged.
- R7: At code 31, a raise request leaves the code at 31. It never wraps to 0.
- R8: At code 0, a lower request leaves the code at 0. It never wraps to 31.
- R9: settled_o goes to 1 after 2 consecutive in-window evaluations. Any out-of-window evaluation clears it and restarts the count. Ignored strobes neither count toward the total nor break the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_active_i | input | 1 | Transmitter active; evaluations are honoured only while 1 |
| eval_i | input | 1 | One-cycle strobe marking the end of a peak-detect window |
| below_lo_i | input | 1 | Peak is under the low threshold |
| above_hi_i | input | 1 | Peak is over the high threshold |
| gain_code_o | output | 5 | Current gain step code, 0 = lowest gain |
| settled_o | output | 1 | Level has stayed inside the window for the required run of evaluations |

## Verification
The hardest states to reach are the upper saturation at code 31 and a settled run that an ignored strobe lands in the middle of. Reaching 31 takes at least 31 accepted raise evaluations in a row, so a directed loop issues more than that number and then checks that one further raise does not wrap. The vector table places a strobe with tx_active_i low between in-window evaluations and puts an out-of-window evaluation right after a single in-window one. This shows that the run counter is neither advanced nor cleared by ignored strobes and does restart on a real miss.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/lvl_decide.sv
module lvl_decide
  import lvl_pkg::*;
(
  input  logic  below_lo_i,
  input  logic  above_hi_i,
  output step_e step_o,
  output logic  in_win_o
);
  // Over-range wins when both flags are set.
  always_comb begin
    if (above_hi_i)      step_o = STEP_DOWN;
    else if (below_lo_i) step_o = STEP_UP;
    else                 step_o = STEP_HOLD;
  end

  assign in_win_o = !below_lo_i && !above_hi_i;
endmodule

// File: rtl/lvl_gain_reg.sv
module lvl_gain_reg
  import lvl_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  step_e             step_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CodeMax = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CodeMin = '0;

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CodeMin;
    end else if (en_i) begin
      unique case (step_i)
        STEP_UP:   if (code_q != CodeMax) code_q <= code_q + 1'b1;
        STEP_DOWN: if (code_q != CodeMin) code_q <= code_q - 1'b1;
        default:   code_q <= code_q;
      endcase
    end
  end

  assign code_o = code_q;

  p_hold_no_eval_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(code_q));

  p_step_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i == STEP_UP && code_q != CodeMax) |=> code_q == $past(code_q) + 1'b1);

  p_step_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i == STEP_DOWN && code_q != CodeMin) |=> code_q == $past(code_q) - 1'b1);

  p_hold_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i == STEP_HOLD) |=> $stable(code_q));

  p_no_wrap_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q == CodeMax && !(en_i && step_i == STEP_DOWN)) |=> code_q == CodeMax);

  p_no_wrap_bot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q == CodeMin && !(en_i && step_i == STEP_UP)) |=> code_q == CodeMin);
endmodule

// File: rtl/lvl_settle.sv
module lvl_settle #(
  parameter int SETTLE_EVALS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic in_win_i,
  output logic settled_o
);
  localparam int CntW = $clog2(SETTLE_EVALS + 1);
  localparam logic [CntW-1:0] CntDone = CntW'(SETTLE_EVALS);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (!in_win_i)             cnt_q <= '0;
      else if (cnt_q != CntDone) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign settled_o = (cnt_q == CntDone);

  p_clear_on_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !in_win_i) |=> !settled_o);

  p_rise_on_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(settled_o) |-> $past(en_i && in_win_i));

  p_settle_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(settled_o));
endmodule

// File: rtl/tx_level_ctrl.sv
module tx_level_ctrl
  import lvl_pkg::*;
#(
  parameter int CODE_W       = 5,
  parameter int SETTLE_EVALS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_active_i,
  input  logic              eval_i,
  input  logic              below_lo_i,
  input  logic              above_hi_i,
  output logic [CODE_W-1:0] gain_code_o,
  output logic              settled_o
);
  step_e step;
  logic  in_win;
  logic  upd;

  assign upd = eval_i && tx_active_i;

  lvl_decide i_decide (
    .below_lo_i (below_lo_i),
    .above_hi_i (above_hi_i),
    .step_o     (step),
    .in_win_o   (in_win)
  );

  lvl_gain_reg #(.CODE_W(CODE_W)) i_gain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (upd),
    .step_i (step),
    .code_o (gain_code_o)
  );

  lvl_settle #(.SETTLE_EVALS(SETTLE_EVALS)) i_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (upd),
    .in_win_i  (in_win),
    .settled_o (settled_o)
  );

  p_both_flags_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && below_lo_i && above_hi_i && gain_code_o != '0)
      |=> gain_code_o == $past(gain_code_o) - 1'b1);
endmodule

// File: tb/test_tx_level_ctrl.sv
module test_tx_level_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx = 1'b0, ev = 1'b0, lo = 1'b0, hi = 1'b0;
  logic [4:0] code;
  logic       settled;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  tx_level_ctrl i_tx_level_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tx_active_i (tx),
    .eval_i      (ev),
    .below_lo_i  (lo),
    .above_hi_i  (hi),
    .gain_code_o (code),
    .settled_o   (settled)
  );

  // {req[3:0], tx, ev, lo, hi, exp_code[4:0], exp_settled}
  localparam int NV = 15;
  localparam logic [13:0] VEC [NV] = '{
    {4'd3, 4'b1110, 5'd1, 1'b0},  // R3 raise
    {4'd3, 4'b1110, 5'd2, 1'b0},  // R3 raise
    {4'd2, 4'b1010, 5'd2, 1'b0},  // R2 no strobe
    {4'd2, 4'b0110, 5'd2, 1'b0},  // R2 not transmitting
    {4'd6, 4'b1100, 5'd2, 1'b0},  // R6 hold, run=1
    {4'd9, 4'b1100, 5'd2, 1'b1},  // R9 run=2 settled
    {4'd9, 4'b1100, 5'd2, 1'b1},  // R9 stays settled
    {4'd4, 4'b1101, 5'd1, 1'b0},  // R4 lower, clears settled
    {4'd5, 4'b1111, 5'd0, 1'b0},  // R5 both flags lower
    {4'd8, 4'b1101, 5'd0, 1'b0},  // R8 floor
    {4'd9, 4'b1100, 5'd0, 1'b0},  // R9 run=1
    {4'd9, 4'b1110, 5'd1, 1'b0},  // R9 miss restarts run
    {4'd9, 4'b1100, 5'd1, 1'b0},  // R9 run=1 again
    {4'd2, 4'b0101, 5'd1, 1'b0},  // R2 ignored strobe keeps run
    {4'd9, 4'b1100, 5'd1, 1'b1}   // R9 run=2 settled
  };

  task automatic check(input string req, input logic [4:0] exp_c, input logic exp_s);
    n_chk++;
    if (code !== exp_c || settled !== exp_s) begin
      n_fail++;
      $display("FAIL %s code=%0d settled=%0b expected code=%0d settled=%0b",
               req, code, settled, exp_c, exp_s);
    end
  endtask

  task automatic step(input logic t, input logic e, input logic l, input logic h);
    @(negedge clk);
    tx = t; ev = e; lo = l; hi = h;
    @(negedge clk);
    ev = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 5'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 5'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
      check($sformatf("R%0d vec%0d", VEC[i][13:10], i), VEC[i][5:1], VEC[i][0]);
    end

    // R1: reset mid-run returns to lowest gain
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1", 5'd0, 1'b0);
    rst_n = 1'b1;

    // R7: climb past the top and confirm no wrap
    for (int k = 0; k < 34; k++) step(1'b1, 1'b1, 1'b1, 1'b0);
    check("R7", 5'd31, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    check("R7", 5'd31, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    check("R4", 5'd30, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    check("R5", 5'd29, 1'b0);

    // R2: held strobe without transmit over many cycles
    @(negedge clk); tx = 1'b0; ev = 1'b1; lo = 1'b1; hi = 1'b0;
    repeat (5) @(negedge clk);
    ev = 1'b0;
    check("R2", 5'd29, 1'b0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule